// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a host-side configuration access port and a fixed set of function configuration ports spread over several buses. A request carries a 32-bit configuration address, a write flag, an access size and write data. The router splits the address into a bus number, a slot, a function and a register offset. It finds the bus whose number matches and forwards the access to the one function port selected by slot and function on that bus. The offset, size, write flag and write data go to every port. A one-hot select strobe, valid for the request cycle only, marks the target.

Bus 0 is the root bus and has a fixed number. Every other bus `b` sits behind a bridge function located on bus `b-1` at slot `BRIDGE_SLOT`, function 0. The number of bus `b` is the byte at register offset 0x19 of that bridge. The router keeps a shadow of that byte, captures it from any write that reaches the bridge and covers that offset, and uses the shadow at once for routing. A shadow starts at 0 after reset.

An access that finds no target is absorbed. A write is dropped. A read returns all-ones data sized to the access. Every read, hit or miss, answers with a response strobe one cycle later.

Top module: `cfg_access_router`

## Requirements
- R1: Address fields are bus = addr[23:16], slot = addr[15:11], function = addr[10:8] and offset = addr[7:0]. Bits [31:24] do not affect routing. `fn_offset` carries addr[7:0] in the request cycle.
- R2: A request whose bus matches, whose slot is below SLOTS, whose function is below FUNCS and whose target is present raises exactly one `fn_sel` bit in the same cycle. That bit is bus_index*SLOTS*FUNCS + slot*FUNCS + function. `fn_write`, `fn_wdata` and `fn_len` pass the request through unchanged.
- R3: Every read request gives `rsp_valid` high for exactly one cycle, on the cycle after the request. On a hit, `rsp_data` is the target's `fn_rdata` with the bytes above the access size forced to zero. A write gives no response.
- R4: A read miss returns 0x000000FF for size code 00 (byte), 0x0000FFFF for 01 (halfword) and 0xFFFFFFFF for 10 or 11 (word). A miss is any of these: no bus matches, the slot or function is out of range, or the target is absent.
- R5: A write miss raises no `fn_sel` bit.
- R6: The root bus (index 0) answers to bus number ROOT_BUS at all times.
- R7: Bus b>=1 has number 0 after reset. A write that reaches the bridge of bus b sets that number when the bytes it covers (byte k at offset+k, taken from `wdata[8k+7:8k]`) include offset 0x19. The new number routes from the next cycle.
- R8: A write to a bridge that does not cover offset 0x19, or a write that misses, leaves every bus number unchanged.
- R9: When several buses carry the requested number, the lowest-indexed bus receives the access.
- R10: With `req_valid` low, no `fn_sel` bit is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Configuration address |
| req_len | input | 2 | Size code: 00 byte, 01 halfword, 1x word |
| req_wdata | input | 32 | Write data, lane 0 at the offset |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read response data |
| fn_present | input | NUM_BUS*SLOTS*FUNCS | Per-port presence flags |
| fn_sel | output | NUM_BUS*SLOTS*FUNCS | One-hot target select |
| fn_write | output | 1 | Write flag to the ports |
| fn_offset | output | 8 | Register offset to the ports |
| fn_len | output | 2 | Size code to the ports |
| fn_wdata | output | 32 | Write data to the ports |
| fn_rdata | input | NUM_BUS*SLOTS*FUNCS*32 | Per-port read data, port p at bits [32p+31:32p] |

## Verification
The bench uses the default shape: three buses in a chain, four slots with two functions each, and the bridges at slot 3. This shape reaches a two-level chain, where the second bridge can only be reached once the first bus number has been programmed. It also reaches the out-of-range slot and function cases, and the case where a bus number clashes with a lower-indexed bus, both at reset (every bus at 0) and after software gives two buses the same number. One function is marked absent, so the all-ones miss path is also exercised on a bus that does match.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

    localparam logic [7:0] SEC_BUS_OFFSET = 8'h19;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] slot;
        logic [2:0] func;
        logic [7:0] offset;
    } cfg_addr_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] lane;
    } lane_pick_t;

    function automatic cfg_addr_t split_addr(input logic [31:0] a);
        cfg_addr_t f;
        f.bus    = a[23:16];
        f.slot   = a[15:11];
        f.func   = a[10:8];
        f.offset = a[7:0];
        return f;
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] len);
        case (acc_size_e'(len))
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] size_mask(input logic [1:0] len);
        case (acc_size_e'(len))
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic lane_pick_t cover_byte(input logic [7:0] offset,
                                              input logic [1:0] len,
                                              input logic [7:0] target);
        lane_pick_t r;
        logic [8:0] end_excl;
        logic [7:0] diff;
        end_excl = {1'b0, offset} + {6'd0, size_bytes(len)};
        diff     = target - offset;
        r.hit    = (offset <= target) && (end_excl > {1'b0, target});
        r.lane   = diff[1:0];
        return r;
    endfunction

endpackage

// File: rtl/cfg_bus_table.sv
module cfg_bus_table
    import cfg_router_pkg::*;
#(
    parameter int NUM_BUS     = 3,
    parameter int SLOTS       = 4,
    parameter int FUNCS       = 2,
    parameter int BRIDGE_SLOT = 3,
    parameter logic [7:0] ROOT_BUS = 8'd0,
    parameter int PW          = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_commit,
    input  logic [PW-1:0]            wr_port,
    input  logic [7:0]               wr_offset,
    input  logic [1:0]               wr_len,
    input  logic [31:0]              wr_data,
    output logic [NUM_BUS-1:0][7:0]  bus_num
);
    localparam int PPB = SLOTS * FUNCS;

    assign bus_num[0] = ROOT_BUS;

    lane_pick_t pick;
    assign pick = cover_byte(wr_offset, wr_len, SEC_BUS_OFFSET);

    for (genvar b = 1; b < NUM_BUS; b++) begin : g_sec
        localparam int BRIDGE_IDX = (b - 1) * PPB + BRIDGE_SLOT * FUNCS;
        logic [7:0] shadow;
        logic       capture;

        assign capture = wr_commit && (int'(wr_port) == BRIDGE_IDX) && pick.hit;

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow <= 8'd0;
            end else if (capture) begin
                shadow <= wr_data[8*pick.lane +: 8];
            end
        end
        assign bus_num[b] = shadow;

        // R8
        bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_num[b] != $past(bus_num[b])) |->
                $past(wr_commit && int'(wr_port) == BRIDGE_IDX));
    end

endmodule

// File: rtl/cfg_target_decode.sv
module cfg_target_decode
    import cfg_router_pkg::*;
#(
    parameter int NUM_BUS = 3,
    parameter int SLOTS   = 4,
    parameter int FUNCS   = 2,
    parameter int NPORT   = 24,
    parameter int PW      = 5
) (
    input  cfg_addr_t                fields,
    input  logic [NUM_BUS-1:0][7:0]  bus_num,
    input  logic [NPORT-1:0]         present,
    output logic                     hit,
    output logic [PW-1:0]            port,
    output logic [NPORT-1:0]         sel
);
    localparam int PPB = SLOTS * FUNCS;

    logic       bus_found;
    int         bus_idx;
    logic       in_range;
    int         idx;

    always_comb begin
        bus_found = 1'b0;
        bus_idx   = 0;
        for (int b = NUM_BUS - 1; b >= 0; b--) begin
            if (bus_num[b] == fields.bus) begin
                bus_found = 1'b1;
                bus_idx   = b;
            end
        end
    end

    always_comb begin
        in_range = bus_found && (int'(fields.slot) < SLOTS) && (int'(fields.func) < FUNCS);
        idx      = bus_idx * PPB + int'(fields.slot) * FUNCS + int'(fields.func);
        if (!in_range) idx = 0;
        port = PW'(idx);
        hit  = in_range && present[idx];
        sel  = '0;
        if (hit) sel[idx] = 1'b1;
    end

endmodule

// File: rtl/cfg_read_return.sv
module cfg_read_return
    import cfg_router_pkg::*;
#(
    parameter int NPORT = 24,
    parameter int PW    = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_fire,
    input  logic               hit,
    input  logic [PW-1:0]      port,
    input  logic [1:0]         len,
    input  logic [NPORT*32-1:0] fn_rdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_data
);
    logic [31:0] picked;
    logic [31:0] mask;

    always_comb begin
        mask   = size_mask(len);
        picked = hit ? (fn_rdata[int'(port)*32 +: 32] & mask) : mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= 32'd0;
        end else begin
            rsp_valid <= rd_fire;
            if (rd_fire) rsp_data <= picked;
        end
    end

    // R3
    rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> rsp_valid);
    // R3
    rsp_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd_fire));
    // R4
    miss_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && !hit) |=> (rsp_data == size_mask($past(len))));

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
    import cfg_router_pkg::*;
#(
    parameter int NUM_BUS     = 3,
    parameter int SLOTS       = 4,
    parameter int FUNCS       = 2,
    parameter int BRIDGE_SLOT = 3,
    parameter logic [7:0] ROOT_BUS = 8'd0,
    parameter int NPORT       = NUM_BUS * SLOTS * FUNCS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [31:0]          req_addr,
    input  logic [1:0]           req_len,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_data,
    input  logic [NPORT-1:0]     fn_present,
    output logic [NPORT-1:0]     fn_sel,
    output logic                 fn_write,
    output logic [7:0]           fn_offset,
    output logic [1:0]           fn_len,
    output logic [31:0]          fn_wdata,
    input  logic [NPORT*32-1:0]  fn_rdata
);
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

    cfg_addr_t                fields;
    logic [NUM_BUS-1:0][7:0]  bus_num;
    logic                     hit;
    logic [PW-1:0]            port;
    logic [NPORT-1:0]         sel_raw;
    logic                     rd_fire;
    logic                     wr_commit;

    assign fields    = split_addr(req_addr);
    assign rd_fire   = req_valid && !req_write;
    assign wr_commit = req_valid && req_write && hit;

    cfg_bus_table #(
        .NUM_BUS(NUM_BUS), .SLOTS(SLOTS), .FUNCS(FUNCS),
        .BRIDGE_SLOT(BRIDGE_SLOT), .ROOT_BUS(ROOT_BUS), .PW(PW)
    ) u_bus_table (
        .clk(clk), .rst(rst),
        .wr_commit(wr_commit), .wr_port(port),
        .wr_offset(fields.offset), .wr_len(req_len), .wr_data(req_wdata),
        .bus_num(bus_num)
    );

    cfg_target_decode #(
        .NUM_BUS(NUM_BUS), .SLOTS(SLOTS), .FUNCS(FUNCS), .NPORT(NPORT), .PW(PW)
    ) u_decode (
        .fields(fields), .bus_num(bus_num), .present(fn_present),
        .hit(hit), .port(port), .sel(sel_raw)
    );

    cfg_read_return #(.NPORT(NPORT), .PW(PW)) u_return (
        .clk(clk), .rst(rst),
        .rd_fire(rd_fire), .hit(hit), .port(port), .len(req_len),
        .fn_rdata(fn_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    assign fn_sel    = req_valid ? sel_raw : '0;
    assign fn_write  = req_write;
    assign fn_offset = fields.offset;
    assign fn_len    = req_len;
    assign fn_wdata  = req_wdata;

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fn_sel));
    // R10
    sel_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (fn_sel == '0));
    // R2
    sel_present_chk: assert property (@(posedge clk) disable iff (rst)
        ((fn_sel & ~fn_present) == '0));

endmodule

// File: tb/test_cfg_access_router.sv
module test_cfg_access_router;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;
    localparam int NS = 4;
    localparam int NF = 2;
    localparam int BSLOT = 3;
    localparam int NP = NB * NS * NF;
    localparam int PPB = NS * NF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_data;
    logic [NP-1:0] fn_present;
    logic [NP-1:0] fn_sel;
    logic fn_write;
    logic [7:0] fn_offset;
    logic [1:0] fn_len;
    logic [31:0] fn_wdata;
    logic [NP*32-1:0] fn_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int mbus [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_router #(.NUM_BUS(NB), .SLOTS(NS), .FUNCS(NF),
                        .BRIDGE_SLOT(BSLOT), .ROOT_BUS(8'd0)) i_cfg_access_router (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fn_present(fn_present),
        .fn_sel(fn_sel), .fn_write(fn_write), .fn_offset(fn_offset),
        .fn_len(fn_len), .fn_wdata(fn_wdata), .fn_rdata(fn_rdata)
    );

    function automatic logic [31:0] port_data(int p, logic [7:0] off);
        return {8'hC3, 8'(p), off, 8'(p) ^ 8'h5A};
    endfunction

    always_comb begin
        for (int p = 0; p < NP; p++) fn_rdata[p*32 +: 32] = port_data(p, fn_offset);
    end

    function automatic logic [31:0] ones(logic [1:0] len);
        if (len == 2'b00) return 32'hFF;
        if (len == 2'b01) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic int nbytes(logic [1:0] len);
        if (len == 2'b00) return 1;
        if (len == 2'b01) return 2;
        return 4;
    endfunction

    function automatic int route(logic [31:0] a);
        int bi = -1;
        int sl = int'(a[15:11]);
        int fu = int'(a[10:8]);
        int idx;
        for (int b = 0; b < NB; b++)
            if (bi < 0 && mbus[b] == int'(a[23:16])) bi = b;
        if (bi < 0 || sl >= NS || fu >= NF) return -1;
        idx = bi * PPB + sl * NF + fu;
        if (!fn_present[idx]) return -1;
        return idx;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int bus, int slot, int fu, int off);
        return {8'h00, 8'(bus), 5'(slot), 3'(fu), 8'(off)};
    endfunction

    task automatic access(bit wr, logic [31:0] a, logic [1:0] len, logic [31:0] wd, string tag);
        int idx;
        logic [NP-1:0] exp_sel;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_len = len; req_wdata = wd;
        #1;
        idx = route(a);
        exp_sel = (idx >= 0) ? (NP'(1) << idx) : '0;
        check(fn_sel == exp_sel, tag, 64'(fn_sel), 64'(exp_sel));
        if (idx >= 0) begin
            check(fn_offset == a[7:0] && fn_write == wr && fn_len == len && fn_wdata == wd,
                  {tag, " R1 R2 passthrough"}, {fn_offset, fn_wdata}, {a[7:0], wd});
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == !wr, {tag, " R3 strobe"}, 64'(rsp_valid), 64'(!wr));
        if (!wr) begin
            logic [31:0] e;
            e = (idx >= 0) ? (port_data(idx, a[7:0]) & ones(len)) : ones(len);
            check(rsp_data == e, tag, 64'(rsp_data), 64'(e));
        end else if (idx >= 0) begin
            for (int b = 1; b < NB; b++) begin
                int off = int'(a[7:0]);
                if (idx == (b-1)*PPB + BSLOT*NF && off <= 'h19 && off + nbytes(len) > 'h19)
                    mbus[b] = int'(wd[8*('h19-off) +: 8]);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        fn_present = '1;
        fn_present[5] = 1'b0;
        for (int b = 0; b < NB; b++) mbus[b] = 0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0 && fn_sel == '0, "R10 reset state", 64'(rsp_valid), 64'd0);
        rst = 1'b0;

        access(0, mk(0, 1, 1, 'h10), 2'b10, 0, "R2 R3 word read hit");
        access(0, mk(0, 0, 0, 'h21), 2'b00, 0, "R3 byte read masked");
        access(0, mk(0, 2, 0, 'h42), 2'b01, 0, "R3 half read masked");
        access(0, mk(0, 2, 1, 'h00), 2'b00, 0, "R4 absent byte");
        access(0, mk(0, 2, 1, 'h00), 2'b01, 0, "R4 absent half");
        access(0, mk(0, 2, 1, 'h00), 2'b11, 0, "R4 absent word code 11");
        access(0, mk(0, 5, 0, 'h00), 2'b10, 0, "R4 slot out of range");
        access(0, mk(0, 1, 3, 'h00), 2'b10, 0, "R4 function out of range");
        access(0, mk(7, 0, 0, 'h00), 2'b01, 0, "R4 unknown bus");
        access(1, mk(0, 1, 0, 'h3C), 2'b10, 32'hDEAD_BEEF, "R2 write hit");
        access(1, mk(7, 1, 0, 'h3C), 2'b10, 32'h1234_5678, "R5 write miss");
        access(1, mk(0, 2, 1, 'h3C), 2'b00, 32'h11, "R5 write absent");
        access(0, mk(0, 0, 1, 'h04), 2'b10, 0, "R9 R7 reset clash root wins");
        access(1, mk(0, BSLOT, 0, 'h18), 2'b10, 32'h0000_0500, "R7 word write bridge");
        access(0, mk(5, 0, 0, 'h08), 2'b10, 0, "R7 bus1 reachable at 5");
        access(1, mk(0, BSLOT, 0, 'h19), 2'b00, 32'h0000_0006, "R7 byte write bridge");
        access(0, mk(6, 1, 1, 'h08), 2'b10, 0, "R7 bus1 at 6");
        access(0, mk(5, 1, 1, 'h08), 2'b10, 0, "R7 old number gone");
        access(1, mk(0, BSLOT, 0, 'h1A), 2'b01, 32'h0000_0909, "R8 half not covering");
        access(1, mk(0, BSLOT, 0, 'h10), 2'b10, 32'h0909_0909, "R8 word not covering");
        access(0, mk(6, 0, 0, 'h00), 2'b10, 0, "R8 bus1 kept 6");
        access(1, mk(6, BSLOT, 0, 'h19), 2'b00, 32'h0000_0009, "R7 second level bridge");
        access(0, mk(9, 2, 0, 'h30), 2'b10, 0, "R7 bus2 at 9");
        access(0, mk(0, 3, 1, 'h30), 2'b10, 0, "R6 root bus fixed");
        access(1, mk(6, BSLOT, 0, 'h18), 2'b01, 32'h0000_0600, "R9 duplicate number");
        access(0, mk(6, 2, 0, 'h30), 2'b10, 0, "R9 lowest bus wins");
        access(0, {8'hFF, 8'h00, 5'd1, 3'd0, 8'h14}, 2'b10, 0, "R1 top bits ignored");
        @(negedge clk); #1;
        check(fn_sel == '0 && rsp_valid == 1'b0, "R10 idle no select", 64'(fn_sel), 64'd0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule